// File: doc/BRIEF.md
# Latch-Based Byte Memory with Two-Cycle Writes

A 64-byte, 8-bit-wide memory. Each storage bit is a level-sensitive latch rather than a flip-flop, which saves area. One clock drives the block. A 6-bit address selects the byte. On every rising edge the address is registered for the read path. The output then shows the addressed byte through a mux tree split into four banks, and exactly one bank is enabled.

A write request is taken into capture registers and sets a pending flag. One clock later a write-valid stage opens the chosen byte's latches, but only for the first half of that cycle. A negative-edge flop closes them again, so the latches load only while the address and data are stable. The hardware drops a second write that arrives directly behind an accepted one. Reset clears the control logic only and leaves the stored bytes as they are.

Top module: `byte_latch_ram`

## Requirements
- R1: The memory holds 64 independent bytes. Address values 0 to 63 each select a distinct byte.
- R2: A synchronous active-low reset clears the write pipeline and the read address register (to address 0). It leaves stored bytes unchanged. A write accepted in the cycle before reset never lands.
- R3: In a cycle with `wr_en` low at the rising edge, `rd_data` shows the byte at the address sampled at that edge.
- R4: When `wr_en` is high at a rising edge and no write is pending, the write is accepted. `addr` and `wr_data` are captured at that edge.
- R5: A write request at the edge right after an accepted write is ignored. That cycle is a plain read and the memory does not change.
- R6: In the cycle where a write is accepted, `rd_data` shows the old content of the addressed byte. If the address is held, the next cycle shows the new value.
- R7: A new write can be accepted two edges after the previous accepted write.
- R8: A write changes only the addressed byte. All other bytes keep their values.
- R9: The write-valid stage is never high in two consecutive cycles. The captured write address stays constant while it is high. The latch gate is closed again by the end of the write cycle.
- R10: Address bits [5:4] pick one of four 16-byte banks through a registered one-hot select. Exactly one bank is selected at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge for control, falling edge for gate shut-off |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| addr | input | 6 | Byte address for both read and write |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte at the registered read address |

## Verification
Suppose the pending flag stays set too long or clears too early. Then the third write of a write-write-write burst is wrongly dropped, or the second is wrongly stored. Either shows at `rd_data` on the first read of that address, two or three cycles later. A wrong latch gate or byte-match decode corrupts a neighbouring byte. That is visible only when that byte is read, so the bench reads back the whole array after each directed group. A stuck bank select shows on the first read whose upper address bits change.

// File: rtl/lram_pkg.sv
// Package: shared sizing for the latch-based byte memory.
// Assumes: the address splits into a bank index (upper bits) and an in-bank index.
package lram_pkg;
    parameter int LRAM_ADDR_W = 6;
    parameter int LRAM_DATA_W = 8;
    parameter int LRAM_BANK_W = 2;
endpackage

// File: rtl/lram_byte_cell.sv
// Module: one byte of level-sensitive storage.
// Assumes: en is a clean pulse, and d is stable while en is high and at its fall.
// No reset: contents survive control reset.
module lram_byte_cell #(
    parameter int DATA_W = lram_pkg::LRAM_DATA_W
) (
    input  logic              en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    // Transparent while en is high, holding otherwise.
    always_latch begin
        if (en) q <= d;
    end
endmodule

// File: rtl/lram_write_ctrl.sv
// Module: write capture, pending/valid pipeline, half-cycle gate and per-byte enables.
// Assumes: one write in flight at a time; a request right after an accepted one is dropped.
module lram_write_ctrl #(
    parameter int ADDR_W = lram_pkg::LRAM_ADDR_W,
    parameter int DATA_W = lram_pkg::LRAM_DATA_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] wdat_q,
    output logic [DEPTH-1:0]  byte_en
);
    logic              pend_q;
    logic              wvalid_q;
    logic              gate_ok_q;
    logic [ADDR_W-1:0] waddr_q;
    logic              take;

    assign take = wr_en & ~pend_q;

    // Capture the address and data of an accepted write.
    always_ff @(posedge clk) begin
        if (take) begin
            waddr_q <= addr;
            wdat_q  <= wr_data;
        end
    end

    // Pending flag follows acceptance; write-valid follows the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            wvalid_q <= 1'b0;
        end else begin
            pend_q   <= take;
            wvalid_q <= pend_q;
        end
    end

    // Falling-edge flop that shuts the gate halfway through the write cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_ok_q <= 1'b1;
        else        gate_ok_q <= ~wvalid_q;
    end

    // Per-byte enable: valid, half-cycle window and address match.
    for (genvar i = 0; i < DEPTH; i++) begin : g_sel
        assign byte_en[i] = wvalid_q & gate_ok_q & (waddr_q == ADDR_W'(i));
    end

    AST_VALID_NOT_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid_q |=> !wvalid_q); // R9
    AST_WADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid_q |-> $stable(waddr_q)); // R9
    AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid_q |-> !gate_ok_q); // R9
    AST_ONE_BYTE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(byte_en)); // R8
    AST_DROP_FOLLOWER: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> !pend_q); // R5
endmodule

// File: rtl/lram_read_mux.sv
// Module: registered read address and banked mux tree with a one-hot bank select.
// Assumes: the bank one-hot is registered straight from the address input.
module lram_read_mux #(
    parameter int ADDR_W = lram_pkg::LRAM_ADDR_W,
    parameter int DATA_W = lram_pkg::LRAM_DATA_W,
    parameter int BANK_W = lram_pkg::LRAM_BANK_W,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int BANKS = 1 << BANK_W,
    localparam int LO_W  = ADDR_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] cells [DEPTH],
    output logic [DATA_W-1:0] rd_data
);
    logic [LO_W-1:0]   lo_q;
    logic [BANKS-1:0]  bank_oh_q;
    logic [DATA_W-1:0] bank_val [BANKS];

    // Register the in-bank index and the decoded bank select every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q      <= '0;
            bank_oh_q <= BANKS'(1);
        end else begin
            lo_q      <= addr[LO_W-1:0];
            bank_oh_q <= BANKS'(1) << addr[ADDR_W-1:LO_W];
        end
    end

    // One in-bank mux per bank.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] BIDX = BANK_W'(b);
        assign bank_val[b] = cells[{BIDX, lo_q}];
    end

    // Merge bank outputs through the one-hot select.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_oh_q[b]) rd_data = rd_data | bank_val[b];
        end
    end

    AST_BANK_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_oh_q) == 1); // R10
endmodule

// File: rtl/byte_latch_ram.sv
// Module: top of the 64x8 latch memory.
// Assumes: single clock; contents are undefined until written and are not reset.
module byte_latch_ram #(
    parameter int ADDR_W = lram_pkg::LRAM_ADDR_W,
    parameter int DATA_W = lram_pkg::LRAM_DATA_W,
    parameter int BANK_W = lram_pkg::LRAM_BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] wdat;
    logic [DEPTH-1:0]  byte_en;
    logic [DATA_W-1:0] cells [DEPTH];

    lram_write_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .wdat_q  (wdat),
        .byte_en (byte_en)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        lram_byte_cell #(.DATA_W(DATA_W)) u_cell (
            .en (byte_en[i]),
            .d  (wdat),
            .q  (cells[i])
        );
    end

    lram_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_rmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .cells   (cells),
        .rd_data (rd_data)
    );
endmodule

// File: tb/test_byte_latch_ram.sv
`timescale 1ns/1ps
module test_byte_latch_ram;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] ref_mem [64];
    bit         known [64];
    bit         m_pend = 0;
    logic [5:0] m_paddr;
    logic [7:0] m_pdata;

    always #5 clk = ~clk;

    byte_latch_ram i_byte_latch_ram (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock with the given inputs; the bench model predicts rd_data after the edge.
    task automatic cyc(input bit rst, input bit we, input logic [5:0] a, input logic [7:0] d, input string req);
        logic [7:0] exp;
        bit         ex_known;
        bit         take;
        rst_n = ~rst; wr_en = we; addr = a; wr_data = d;
        @(negedge clk);
        if (rst) begin
            m_pend   = 0;
            exp      = ref_mem[0];
            ex_known = known[0];
        end else begin
            if (m_pend) begin
                ref_mem[m_paddr] = m_pdata;
                known[m_paddr]   = 1;
            end
            exp      = ref_mem[a];
            ex_known = known[a];
            take     = we && !m_pend;
            m_pend   = take;
            if (take) begin
                m_paddr = a;
                m_pdata = d;
            end
        end
        if (ex_known) check(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 64; i++) cyc(0, 0, 6'(i), 8'h00, req);
    endtask

    // R1 R4: fill every byte with a distinct pattern, then read all back.
    task automatic t_fill();
        for (int i = 0; i < 64; i++) begin
            cyc(0, 1, 6'(i), 8'(i * 7 + 3), "R4");
            cyc(0, 0, 6'(i), 8'h00, "R1");
        end
        read_all("R1");
    endtask

    // R3 R10: reads hopping across all four banks.
    task automatic t_banks();
        for (int k = 0; k < 16; k++) begin
            cyc(0, 0, 6'({2'(k % 4), 4'(k)}), 8'h00, "R10");
            cyc(0, 0, 6'({2'(3 - k % 4), 4'(15 - k)}), 8'h00, "R3");
        end
    endtask

    // R6: old value while accepting, new value on the next cycle.
    task automatic t_readback();
        cyc(0, 1, 6'd21, 8'hA5, "R6");
        cyc(0, 0, 6'd21, 8'h00, "R6");
        check(rd_data === 8'hA5, "R6", rd_data, 8'hA5);
    endtask

    // R5 R8: a second write directly behind an accepted one is dropped.
    task automatic t_back2back();
        cyc(0, 1, 6'd40, 8'h3C, "R5");
        cyc(0, 1, 6'd41, 8'hC3, "R5");
        cyc(0, 0, 6'd41, 8'h00, "R5");
        cyc(0, 0, 6'd40, 8'h00, "R8");
        check(rd_data === 8'h3C, "R8", rd_data, 8'h3C);
        read_all("R8");
    endtask

    // R7: write, dropped write, then a write two edges later is accepted.
    task automatic t_spacing();
        cyc(0, 1, 6'd10, 8'h11, "R7");
        cyc(0, 1, 6'd11, 8'h22, "R7");
        cyc(0, 1, 6'd12, 8'h33, "R7");
        cyc(0, 0, 6'd12, 8'h00, "R7");
        check(rd_data === 8'h33, "R7", rd_data, 8'h33);
        cyc(0, 0, 6'd11, 8'h00, "R7");
    endtask

    // R2: reset keeps contents, points reads at byte 0, and cancels an accepted write.
    task automatic t_reset();
        cyc(0, 1, 6'd50, 8'h77, "R2");
        cyc(1, 0, 6'd50, 8'h00, "R2");
        check(rd_data === ref_mem[0], "R2", rd_data, ref_mem[0]);
        cyc(0, 0, 6'd50, 8'h00, "R2");
        read_all("R2");
    endtask

    // R3 R5 R6: random traffic including write bursts.
    task automatic t_random();
        for (int i = 0; i < 600; i++)
            cyc(0, ($urandom % 3) != 0, 6'($urandom), 8'($urandom), "R3");
        read_all("R3");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) known[i] = 0;
        cyc(1, 0, 6'd0, 8'h00, "R2");
        cyc(1, 0, 6'd0, 8'h00, "R2");
        t_fill();
        t_banks();
        t_readback();
        t_back2back();
        t_spacing();
        t_reset();
        t_random();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule